// File: doc/BRIEF.md
# Receive Byte Ring with Sender Throttling

This block is an elastic store for bytes arriving from a serial receiver. It holds up to 32 bytes in a circular array. A write pointer advances on every accepted byte, a read pointer advances on every consumed byte, and an occupancy counter tracks how many are held. The consumer always sees the oldest stored byte on its data output. It takes that byte with a one-cycle strobe.

To keep the remote sender from overrunning the store, the block drives a request-to-send level with hysteresis. The level drops when arrivals fill the store to half its depth. It rises again only when the consumer has drained it to a quarter. The wide gap keeps the line from toggling on every byte. When throttling is switched off, the line stays asserted. A byte that arrives with the store already full is thrown away, and a one-cycle drop pulse reports it. A synchronous flush returns the store to its empty state.

Top module: `rx_byte_ring`

## Requirements
- R1: After reset, the occupancy is 0, `has_data` is 0, `drop_pulse` is 0 and `rts_ok` is 1. The occupancy never exceeds 32.
- R2: A `wr_stb` with occupancy below 32 stores `wr_data` and raises the occupancy by one, visible after the clock edge. The write position wraps from entry 31 to entry 0.
- R3: A `wr_stb` while the occupancy is 32 is discarded, even when a pop falls in the same cycle. The stored contents stay unchanged. `drop_pulse` is high for exactly the one cycle after each discarded byte.
- R4: While the store is non-empty, `rd_data` shows the oldest byte. A `rd_stb` removes it and lowers the occupancy by one. Bytes leave in arrival order across any number of wraps.
- R5: A `rd_stb` with the store empty is ignored, and the occupancy stays 0.
- R6: A write and a read in the same cycle, with occupancy between 1 and 31, leave the occupancy unchanged and preserve arrival order.
- R7: With `fc_en` high, `rts_ok` goes low in the cycle after a write without a read takes the occupancy from 15 to 16.
- R8: With `fc_en` high, `rts_ok` goes high in the cycle after a read without a write takes the occupancy from 9 to 8. No other change of occupancy moves `rts_ok`.
- R9: While `fc_en` is low, `rts_ok` is 1 from the cycle after it was sampled low.
- R10: `flush` takes priority over both strobes. In the next cycle the occupancy is 0, `rts_ok` is 1 and no drop is reported. The next stored byte is the one presented on `rd_data`.
- R11: `has_data` is 1 exactly when the occupancy is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous return to the empty state |
| fc_en | input | 1 | Enables throttling of the sender |
| wr_stb | input | 1 | A received byte is present |
| wr_data | input | 8 | Received byte |
| rd_stb | input | 1 | Consumer takes the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| fill_cnt | output | 6 | Occupancy, 0 to 32 |
| has_data | output | 1 | Occupancy is non-zero |
| drop_pulse | output | 1 | One cycle per discarded byte |
| rts_ok | output | 1 | Sender may transmit |

## Verification
A write and a read can land in the same cycle. That interaction carries most of the risk. The bench provokes it with long interleaved strobe patterns that keep the store partly filled while both pointers wrap several times. It also issues a write and a read together while the store is full, so the write is dropped and the read still succeeds. A queue model in the bench judges every cycle: it checks occupancy, oldest byte, drop pulse and the throttle level, and confirms that simultaneous traffic never moves the throttle.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic {
    FLOW_HOLD = 1'b0,
    FLOW_GO   = 1'b1
  } flow_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (flush)
      ptr_nxt = '0;
    else if (adv)
      ptr_nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  assign rdata = mem[raddr];
endmodule

// File: rtl/fill_ctr.sv
module fill_ctr #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_stb,
  input  logic          rd_stb,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          drop_q
);
  logic full, empty, drop_nxt;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign push_ok  = !flush && wr_stb && !full;
  assign pop_ok   = !flush && rd_stb && !empty;
  assign drop_nxt = !flush && wr_stb && full;

  always_comb begin
    cnt_nxt = cnt;
    if (flush)
      cnt_nxt = '0;
    else if (push_ok && !pop_ok)
      cnt_nxt = cnt + 1'b1;
    else if (pop_ok && !push_ok)
      cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      drop_q <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      drop_q <= drop_nxt;
    end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3
  full_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && wr_stb && !rd_stb && !flush) |=> cnt == CW'(DEPTH));
  // R3
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> ($past(wr_stb) && $past(cnt) == CW'(DEPTH)));
  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rd_stb && !wr_stb && !flush) |=> cnt == '0);
  // R6
  both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rd_stb && !flush && cnt != '0 && cnt != CW'(DEPTH)) |=> $stable(cnt));
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst
  import rx_ring_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int HI_MARK = 16,
  parameter int LO_MARK = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fc_en,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [CW-1:0] cnt_nxt,
  output logic          rts
);
  flow_e st, st_nxt;

  always_comb begin
    st_nxt = st;
    if (flush || !fc_en)
      st_nxt = FLOW_GO;
    else if (push_ok && !pop_ok && cnt_nxt == CW'(HI_MARK))
      st_nxt = FLOW_HOLD;
    else if (pop_ok && !push_ok && cnt_nxt == CW'(LO_MARK))
      st_nxt = FLOW_GO;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= FLOW_GO;
    else        st <= st_nxt;

  assign rts = (st == FLOW_GO);

  // R9
  fc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> rts);
endmodule

// File: rtl/rx_byte_ring.sv
module rx_byte_ring #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int HI_MARK = DEPTH / 2,
  localparam int LO_MARK = DEPTH / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fc_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stb,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill_cnt,
  output logic          has_data,
  output logic          drop_pulse,
  output logic          rts_ok
);
  logic          push_ok, pop_ok;
  logic [CW-1:0] cnt_nxt;
  logic [AW-1:0] head, tail;

  fill_ctr #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .push_ok(push_ok), .pop_ok(pop_ok), .cnt(fill_cnt), .cnt_nxt(cnt_nxt),
    .drop_q(drop_pulse)
  );

  ring_ptr #(.DEPTH(DEPTH)) u_head (
    .clk(clk), .rst_n(rst_n), .flush(flush), .adv(push_ok), .ptr(head)
  );

  ring_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk(clk), .rst_n(rst_n), .flush(flush), .adv(pop_ok), .ptr(tail)
  );

  ring_store #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(push_ok), .waddr(head), .wdata(wr_data),
    .raddr(tail), .rdata(rd_data)
  );

  rts_hyst #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_rts (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fc_en(fc_en),
    .push_ok(push_ok), .pop_ok(pop_ok), .cnt_nxt(cnt_nxt), .rts(rts_ok)
  );

  assign has_data = (fill_cnt != '0);

  // R2
  ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(head - tail) == fill_cnt[AW-1:0]);
  // R7
  rts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_ok) |-> fill_cnt == CW'(HI_MARK));
  // R8
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_ok) && $past(fc_en) && !$past(flush)) |-> fill_cnt == CW'(LO_MARK));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_cnt == '0 && rts_ok && !drop_pulse));
endmodule

// File: tb/tb_rx_byte_ring.sv
`timescale 1ns/1ps
module tb_rx_byte_ring;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       fc_en = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic [5:0] fill_cnt;
  logic       has_data, drop_pulse, rts_ok;

  int checks = 0;
  int errors = 0;
  logic [7:0] q[$];
  bit rts_m = 1'b1;

  always #2.5 clk = ~clk;

  rx_byte_ring dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fc_en(fc_en),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .fill_cnt(fill_cnt), .has_data(has_data), .drop_pulse(drop_pulse), .rts_ok(rts_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit w, input logic [7:0] d, input bit r, input string tag);
    bit full_m, push_m, pop_m, drop_m;
    full_m = (q.size() == 32);
    push_m = w && !full_m;
    pop_m  = r && (q.size() != 0);
    if (q.size() != 0) chk("R4 data", int'(rd_data), int'(q[0]));
    wr_stb = w; wr_data = d; rd_stb = r;
    @(posedge clk);
    if (pop_m) void'(q.pop_front());
    if (push_m) q.push_back(d);
    drop_m = w && full_m;
    if (!fc_en) rts_m = 1'b1;
    else if (push_m && !pop_m && q.size() == 16) rts_m = 1'b0;
    else if (pop_m && !push_m && q.size() == 8) rts_m = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    chk(tag, int'(fill_cnt), q.size());
    chk("R11", int'(has_data), int'(q.size() != 0));
    chk("R7 R8 R9 rts", int'(rts_ok), int'(rts_m));
    chk("R3 drop", int'(drop_pulse), int'(drop_m));
  endtask

  task automatic do_flush();
    flush = 1'b1; wr_stb = 1'b1; rd_stb = 1'b1; wr_data = 8'hEE;
    @(posedge clk);
    q.delete(); rts_m = 1'b1;
    @(negedge clk);
    flush = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    chk("R10 count", int'(fill_cnt), 0);
    chk("R10 rts", int'(rts_ok), 1);
    chk("R10 drop", int'(drop_pulse), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(fill_cnt), 0);
    chk("R1 has_data", int'(has_data), 0);
    chk("R1 drop", int'(drop_pulse), 0);
    chk("R1 rts", int'(rts_ok), 1);

    // R5 pops on empty store
    for (int i = 0; i < 3; i++) cycle(1'b0, 8'h00, 1'b1, "R5");

    // R2 fill sweep to full; throttle falls at 16 (R7)
    for (int i = 0; i < 32; i++) cycle(1'b1, 8'(i * 7 + 3), 1'b0, "R2");

    // R3 arrivals while full, separated by idle cycles
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 8'hA5, 1'b0, "R3");
      cycle(1'b0, 8'h00, 1'b0, "R3");
    end
    // R3 write dropped even with a pop in the same cycle
    cycle(1'b1, 8'h5A, 1'b1, "R3");

    // R4 drain sweep; throttle rises at 8 (R8)
    while (q.size() != 0) cycle(1'b0, 8'h00, 1'b1, "R4");

    // R6 interleaved traffic wrapping both pointers several times
    for (int k = 0; k < 240; k++) begin
      bit w, r;
      w = (k % 5) != 4;
      r = ((k % 3) != 0) && (k > 10);
      cycle(w, 8'(k * 13 + 1), r, "R6");
    end
    // R6 push and pop together from many fill levels
    for (int lvl = 1; lvl < 32; lvl += 5) begin
      while (q.size() < lvl) cycle(1'b1, 8'(q.size() + 40), 1'b0, "R2");
      while (q.size() > lvl) cycle(1'b0, 8'h00, 1'b1, "R4");
      cycle(1'b1, 8'(lvl), 1'b1, "R6");
    end
    while (q.size() != 0) cycle(1'b0, 8'h00, 1'b1, "R4");

    // R9 throttling disabled across the high mark
    fc_en = 1'b0;
    for (int i = 0; i < 20; i++) cycle(1'b1, 8'(i + 100), 1'b0, "R9");
    fc_en = 1'b1;
    while (q.size() > 8) cycle(1'b0, 8'h00, 1'b1, "R8");
    for (int i = 0; i < 10; i++) cycle(1'b1, 8'(i + 200), 1'b0, "R7");

    // R10 flush with both strobes active
    do_flush();
    cycle(1'b1, 8'h3C, 1'b0, "R10");
    chk("R10 first byte", int'(rd_data), 8'h3C);
    cycle(1'b0, 8'h00, 1'b1, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule